// File: doc/BRIEF.md
# I2C Interrupt Status and Clear Unit

This unit gathers the event sources of an I2C master controller into a twelve-bit raw status word. Single-cycle event pulses from the bus engine set sticky bits, and two FIFO threshold levels pass straight through. A mask register selects which raw bits reach the masked status word, and the OR of the masked word drives one interrupt line.

Software never writes ones to acknowledge an event. Instead, every sticky event has a dedicated clear register. A strobed read of that register returns the bit's current value in bit 0 and clears the bit on the same clock edge. A combined clear register drops every sticky bit at once.

The unit sees only a register index, a read strobe and a mask write port. Address decode, the bus engine and the FIFOs sit outside it.

Top module: `i2cIrqTop`

## Requirements
- R1: Raw status bits, by position: 0 rx_under, 1 rx_over, 2 rx_full, 3 tx_over, 4 tx_empty, 5 rd_req, 6 tx_abort, 7 rx_done, 8 activity, 9 stop_det, 10 start_det, 11 gen_call. The sticky bits are those in mask 12'hFEB. A pulse on `evtIn[b]` for a sticky bit sets raw bit b from the next cycle, and the bit stays set until it is cleared. Index 2 reads the raw word.
- R2: Raw bits 2 and 4 equal `evtIn[2]` and `evtIn[4]` in the same cycle. No read changes them.
- R3: Index 1 reads the mask register, which `maskWe`/`maskWdata` load on the clock edge. Index 0 reads the masked status, which is raw AND mask.
- R4: `irq` is high exactly when the masked status is non-zero.
- R5: A strobed read of index 4+b, for a sticky bit b, clears only raw bit b. Indices 6 and 8 have no clear effect.
- R6: A read of index 4+b returns raw bit b in bit 0, with all other bits zero, as the bit was before the clear. Index 3 returns in bit 0 the OR of all sticky bits. Indices 6 and 8 read zero.
- R7: A strobed read of index 3 clears every sticky bit.
- R8: If a sticky bit's event arrives in the same cycle as a read that clears it, the bit stays set.
- R9: Raw status keeps updating and stays readable whatever the mask holds.
- R10: Reset clears the mask and all sticky bits, so `irq` is low.
- R11: A read with `rdStrobe` low, or a read of indices 0 to 2, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 12 | Event pulses for sticky bits; FIFO levels on bits 2 and 4 |
| maskWe | input | 1 | Mask register load enable |
| maskWdata | input | 12 | New mask value |
| rdStrobe | input | 1 | Read strobe; triggers the clear side effects |
| rdIndex | input | 4 | Register index |
| irq | output | 1 | Interrupt line |
| rdData | output | 12 | Read data for the indexed register |

## Verification
The two functions that can fall in one cycle are setting a sticky bit and clearing it. The bench provokes this in two ways. It drives each sticky event in the same cycle as a strobed read of that bit's clear register. It also drives all events together with a strobed read of the combined clear register. It judges the outcome by reading the raw word on the next cycle, where the bit must still be set. Separately, it sweeps every mask value against a fully set raw word, with varying FIFO levels, to check the masked status and the interrupt line.

// File: rtl/i2cIrqPkg.sv
package i2cIrqPkg;
  localparam int STAT_W = 12;
  localparam int IDX_W  = 4;

  // Raw status bit positions (the layout software decodes)
  localparam int BIT_RX_UNDER  = 0;
  localparam int BIT_RX_OVER   = 1;
  localparam int BIT_RX_FULL   = 2;
  localparam int BIT_TX_OVER   = 3;
  localparam int BIT_TX_EMPTY  = 4;
  localparam int BIT_RD_REQ    = 5;
  localparam int BIT_TX_ABORT  = 6;
  localparam int BIT_RX_DONE   = 7;
  localparam int BIT_ACTIVITY  = 8;
  localparam int BIT_STOP_DET  = 9;
  localparam int BIT_START_DET = 10;
  localparam int BIT_GEN_CALL  = 11;

  localparam logic [STAT_W-1:0] LEVEL_MASK =
    STAT_W'((1 << BIT_RX_FULL) | (1 << BIT_TX_EMPTY));
  localparam logic [STAT_W-1:0] CLEAR_MASK = ~LEVEL_MASK;

  // Register index map
  localparam int IDX_MASKED   = 0;
  localparam int IDX_MASK     = 1;
  localparam int IDX_RAW      = 2;
  localparam int IDX_CLR_ALL  = 3;
  localparam int IDX_CLR_BASE = 4;

  typedef struct packed {
    logic [STAT_W-1:0] clrOne;
    logic              clrAll;
    logic              maskLoad;
  } ctlStrobe_t;
endpackage

// File: rtl/i2cIrqCtl.sv
module i2cIrqCtl
  import i2cIrqPkg::*;
(
  input  logic             rdStrobe,
  input  logic [IDX_W-1:0] rdIndex,
  input  logic             maskWe,
  output ctlStrobe_t       strobes
);
  logic [STAT_W-1:0] clrVec;

  for (genvar i = 0; i < STAT_W; i++) begin : gDecode
    if (CLEAR_MASK[i]) begin : gClr
      assign clrVec[i] = rdStrobe && (rdIndex == IDX_W'(IDX_CLR_BASE + i));
    end else begin : gLvl
      assign clrVec[i] = 1'b0;
    end
  end

  always_comb begin
    strobes.clrOne   = clrVec;
    strobes.clrAll   = rdStrobe && (rdIndex == IDX_W'(IDX_CLR_ALL));
    strobes.maskLoad = maskWe;
  end
endmodule

// File: rtl/i2cIrqDp.sv
module i2cIrqDp
  import i2cIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] evtIn,
  input  ctlStrobe_t        strobes,
  input  logic [STAT_W-1:0] maskWdata,
  input  logic [IDX_W-1:0]  rdIndex,
  output logic [STAT_W-1:0] rawStat,
  output logic [STAT_W-1:0] maskReg,
  output logic              irq,
  output logic [STAT_W-1:0] rdData
);
  logic [STAT_W-1:0] maskedStat;

  for (genvar i = 0; i < STAT_W; i++) begin : gBit
    if (CLEAR_MASK[i]) begin : gSticky
      logic latBit;
      always_ff @(posedge clk) begin
        if (!rstN)                                 latBit <= 1'b0;
        else if (evtIn[i])                         latBit <= 1'b1;
        else if (strobes.clrOne[i] || strobes.clrAll) latBit <= 1'b0;
      end
      assign rawStat[i] = latBit;
    end else begin : gLevel
      assign rawStat[i] = evtIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 maskReg <= '0;
    else if (strobes.maskLoad) maskReg <= maskWdata;
  end

  assign maskedStat = rawStat & maskReg;
  assign irq        = |maskedStat;

  always_comb begin
    rdData = '0;
    case (rdIndex)
      IDX_W'(IDX_MASKED):  rdData = maskedStat;
      IDX_W'(IDX_MASK):    rdData = maskReg;
      IDX_W'(IDX_RAW):     rdData = rawStat;
      IDX_W'(IDX_CLR_ALL): rdData[0] = |(rawStat & CLEAR_MASK);
      default: begin
        for (int i = 0; i < STAT_W; i++) begin
          if (CLEAR_MASK[i] && (rdIndex == IDX_W'(IDX_CLR_BASE + i)))
            rdData[0] = rawStat[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/i2cIrqTop.sv
module i2cIrqTop
  import i2cIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] evtIn,
  input  logic              maskWe,
  input  logic [STAT_W-1:0] maskWdata,
  input  logic              rdStrobe,
  input  logic [IDX_W-1:0]  rdIndex,
  output logic              irq,
  output logic [STAT_W-1:0] rdData
);
  ctlStrobe_t        strobes;
  logic [STAT_W-1:0] rawStat;
  logic [STAT_W-1:0] maskReg;

  i2cIrqCtl uCtl (
    .rdStrobe (rdStrobe),
    .rdIndex  (rdIndex),
    .maskWe   (maskWe),
    .strobes  (strobes)
  );

  i2cIrqDp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .strobes   (strobes),
    .maskWdata (maskWdata),
    .rdIndex   (rdIndex),
    .rawStat   (rawStat),
    .maskReg   (maskReg),
    .irq       (irq),
    .rdData    (rdData)
  );
endmodule

// File: rtl/i2cIrqChk.sv
module i2cIrqChk
  import i2cIrqPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [STAT_W-1:0] evtIn,
  input logic              rdStrobe,
  input logic [IDX_W-1:0]  rdIndex,
  input logic              irq,
  input logic [STAT_W-1:0] rdData,
  input logic [STAT_W-1:0] rawStat
);
  assert_irq_matches_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdIndex == IDX_W'(IDX_MASKED)) |-> (irq == (rdData != '0)));

  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdIndex == IDX_W'(IDX_CLR_ALL) && ((evtIn & CLEAR_MASK) == '0))
      |=> ((rawStat & CLEAR_MASK) == '0));

  for (genvar i = 0; i < STAT_W; i++) begin : gBitChk
    if (CLEAR_MASK[i]) begin : gSticky
      assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
        (rdStrobe && evtIn[i] &&
         (rdIndex == IDX_W'(IDX_CLR_ALL) || rdIndex == IDX_W'(IDX_CLR_BASE + i)))
          |=> rawStat[i]);

      assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
        (rawStat[i] && !(rdStrobe &&
         (rdIndex == IDX_W'(IDX_CLR_ALL) || rdIndex == IDX_W'(IDX_CLR_BASE + i))))
          |=> rawStat[i]);

      assert_clear_one_R5: assert property (@(posedge clk) disable iff (!rstN)
        (rdStrobe && !evtIn[i] && rdIndex == IDX_W'(IDX_CLR_BASE + i))
          |=> !rawStat[i]);

      assert_clear_value_R6: assert property (@(posedge clk) disable iff (!rstN)
        (rdIndex == IDX_W'(IDX_CLR_BASE + i)) |-> (rdData == STAT_W'(rawStat[i])));
    end
  end
endmodule

bind i2cIrqTop i2cIrqChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .evtIn    (evtIn),
  .rdStrobe (rdStrobe),
  .rdIndex  (rdIndex),
  .irq      (irq),
  .rdData   (rdData),
  .rawStat  (rawStat)
);

// File: tb/tb_i2cIrqTop.sv
`timescale 1ns/1ps
module tb_i2cIrqTop;
  localparam logic [11:0] CLR = 12'hFEB;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] evtIn = '0;
  logic        maskWe = 1'b0;
  logic [11:0] maskWdata = '0;
  logic        rdStrobe = 1'b0;
  logic [3:0]  rdIndex = '0;
  logic        irq;
  logic [11:0] rdData;

  int nChecks = 0;
  int nFail = 0;
  logic done = 1'b0;

  logic [11:0] mLat = '0;
  logic [11:0] mMask = '0;

  always #2.5 clk = ~clk;

  i2cIrqTop dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .maskWe(maskWe),
    .maskWdata(maskWdata), .rdStrobe(rdStrobe), .rdIndex(rdIndex),
    .irq(irq), .rdData(rdData)
  );

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [11:0] ev, logic st, logic [3:0] ix,
                      logic mwe = 1'b0, logic [11:0] md = '0);
    logic [11:0] raw, exp, clr;
    @(negedge clk);
    evtIn = ev; rdStrobe = st; rdIndex = ix; maskWe = mwe; maskWdata = md;
    #1;
    raw = (mLat & CLR) | (ev & ~CLR);
    exp = '0;
    case (ix)
      4'd0: exp = raw & mMask;
      4'd1: exp = mMask;
      4'd2: exp = raw;
      4'd3: exp[0] = |(mLat & CLR);
      default: exp[0] = CLR[ix - 4'd4] & mLat[ix - 4'd4];
    endcase
    check(tag, rdData, exp);
    check("R4 irq", {11'b0, irq}, {11'b0, |(raw & mMask)});
    @(posedge clk);
    clr = '0;
    if (st) begin
      if (ix == 4'd3) clr = CLR;
      else if (ix >= 4'd4) clr = CLR & (12'd1 << (ix - 4'd4));
    end
    mLat = ((mLat & ~clr) | ev) & CLR;
    if (mwe) mMask = md;
    @(negedge clk);
    evtIn = '0; rdStrobe = 1'b0; maskWe = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rdIndex = 4'd1; #1; check("R10 mask reset", rdData, 12'h000);
    rdIndex = 4'd2; #1; check("R10 raw reset", rdData, 12'h000);
    check("R10 irq reset", {11'b0, irq}, 12'h000);
    rstN = 1'b1;

    // R1 and R2: each source alone, then sticky check and clear-all
    for (int b = 0; b < 12; b++) begin
      step("R2 level same cycle", 12'd1 << b, 1'b0, 4'd2);
      step("R1 sticky next cycle", 12'h000, 1'b0, 4'd2);
      step("R7 clear all read", 12'h000, 1'b1, 4'd3);
      step("R7 all cleared", 12'h000, 1'b0, 4'd2);
    end

    // R3, R4, R9: exhaustive mask sweep over a full raw word
    for (int m = 0; m < 4096; m++) begin
      logic [11:0] lv;
      lv = (m[0] ? 12'h004 : 12'h000) | (m[5] ? 12'h010 : 12'h000);
      step("R9 raw ignores mask", CLR | lv, 1'b0, 4'd2, 1'b1, 12'(m));
      step("R3 masked status", lv, 1'b0, (m % 3 == 0) ? 4'd1 : 4'd0);
    end
    step("R3 mask zero", 12'h000, 1'b0, 4'd1, 1'b1, 12'hFFF);

    // R5, R6: individual clears
    for (int b = 0; b < 12; b++) begin
      step("R5 set all", CLR, 1'b0, 4'd2);
      step("R6 clear read value", 12'h000, 1'b1, 4'(b + 4));
      step("R5 only that bit cleared", 12'h000, 1'b0, 4'd2);
      step("R6 second read zero", 12'h000, 1'b0, 4'(b + 4));
    end
    step("R7 clear rest", 12'h000, 1'b1, 4'd3);

    // R8: event coincides with clearing read
    for (int b = 0; b < 12; b++) begin
      step("R8 event with clear", 12'd1 << b, 1'b1, 4'(b + 4));
      step("R8 event wins", 12'h000, 1'b0, 4'd2);
      step("R8 clear again", 12'h000, 1'b1, 4'(b + 4));
      step("R8 now clear", 12'h000, 1'b0, 4'd2);
    end
    step("R8 all with clear all", CLR, 1'b1, 4'd3);
    step("R8 all survive", 12'h000, 1'b0, 4'd2);

    // R11: reads without side effects
    for (int ix = 0; ix < 16; ix++) begin
      step("R11 unstrobed read", 12'h000, 1'b0, 4'(ix));
      step("R11 state kept", 12'h000, 1'b0, 4'd2);
    end
    for (int ix = 0; ix < 3; ix++) begin
      step("R11 plain strobed read", 12'h000, 1'b1, 4'(ix));
      step("R11 state kept", 12'h000, 1'b0, 4'd2);
    end
    step("R5 index 6 no effect", 12'h004, 1'b1, 4'd6);
    step("R5 index 8 no effect", 12'h010, 1'b1, 4'd8);
    step("R2 level under clear all", 12'h014, 1'b1, 4'd3);
    step("R2 level after clears", 12'h014, 1'b0, 4'd2);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule